// File: doc/BRIEF.md
# Sensor read-back and interrupt request unit

This block sits between a host's parallel input port and an analog and binary sensing front end. It builds the 16-bit word the host sees when it reads the input port. A 2-bit function select chooses what that word holds: the most recent converter result, the synchronized touch and stop-button bits, or zeros for the functions that only write.

It also keeps two request flags. The conversion flag tells the host that a converter result is waiting. A channel write clears it, a conversion-done pulse sets it, and a read of the converter word clears it. The sensor flag records a new activation of any touch or stop input. A read of the sensor word clears it. Each flag drives an interrupt line through the host's enable bits; the sensor line also passes through a local touch interrupt enable. Converter sequencing and interrupt vector delivery sit outside this block.

Top module: `sir_top`

## Requirements
- R1: After reset both interrupt lines are low, and the read word is zero for every select value while the touch and stop inputs are low.
- R2: With select 2'b10 the read word carries the result captured at the last conversion-done pulse in bits 11..0, with bits 15..12 zero. The result is 0 before the first capture.
- R3: With select 2'b11 the read word carries the stop bit at bit 7 and touch bits 1..0, with touch input 0 at bit 0. All other bits are zero. These inputs pass through a two-flop synchronizer, so a change appears in the word two clock edges after it is applied.
- R4: With select 2'b00 or 2'b01 the read word is all zeros.
- R5: A conversion-done pulse sets the conversion flag. The conversion interrupt line equals that flag ANDed with the host conversion interrupt enable.
- R6: A channel-write strobe clears the conversion flag.
- R7: A read strobe with select 2'b10 clears the conversion flag. A read strobe with any other select leaves it unchanged.
- R8: When a set and a clear of the same flag arrive in one cycle, the set wins and the flag ends up high.
- R9: The sensor flag is set on a rising edge of the OR of the synchronized touch and stop bits. A level that stays high after the flag is cleared does not set it again.
- R10: The sensor interrupt line equals the sensor flag ANDed with the touch interrupt enable and with the host sensor interrupt enable. The flag itself is recorded whatever the enables are.
- R11: A read strobe with select 2'b11 clears the sensor flag. A read strobe with any other select leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fn_sel | input | 2 | Function select that chooses the read word |
| rd_stb | input | 1 | One-cycle host read strobe of the input port |
| chan_wr | input | 1 | One-cycle strobe marking a write of a converter channel |
| adc_data | input | 12 | Converter result |
| adc_done | input | 1 | One-cycle pulse: conversion complete, adc_data valid |
| touch_in | input | 2 | Asynchronous touch sensor inputs |
| panic_in | input | 1 | Asynchronous stop-button input |
| sense_int_en | input | 1 | Local enable for the sensor interrupt |
| host_ien_a | input | 1 | Host enable for the conversion interrupt |
| host_ien_b | input | 1 | Host enable for the sensor interrupt |
| rd_data | output | 16 | Word returned to the host |
| irq_a | output | 1 | Conversion interrupt request |
| irq_b | output | 1 | Sensor interrupt request |

## Verification
Two situations are hard to reach from the ports. The first is a flag seeing its set and its clear on the same edge. The bench reaches it by raising adc_done in the same drive cycle as a channel write, and again with a converter read. The second is a stop level held high across the read that clears the sensor flag. The bench reaches it by keeping the input asserted for several cycles after the clearing read and confirming that the sensor line stays low until a fresh edge arrives on a touch input.

// File: rtl/sir_pkg.sv
package sir_pkg;
   typedef enum logic [1:0] {
      SEL_OUT0  = 2'b00,
      SEL_OUT1  = 2'b01,
      SEL_CONV  = 2'b10,
      SEL_SENSE = 2'b11
   } fn_sel_e;
endpackage

// File: rtl/sir_sync.sv
module sir_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("sir_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] stage [STAGES];

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) stage[gi] <= '0;
               else        stage[gi] <= d;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) stage[gi] <= '0;
               else        stage[gi] <= stage[gi-1];
         end
      end
   endgenerate

   assign q = stage[STAGES-1];
endmodule

// File: rtl/sir_req_flag.sv
module sir_req_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);
   // set has priority over clear
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)   q <= 1'b0;
      else if (set) q <= 1'b1;
      else if (clr) q <= 1'b0;
endmodule

// File: rtl/sir_rdmux.sv
module sir_rdmux
   import sir_pkg::*;
#(
   parameter int ADC_W     = 12,
   parameter int TOUCH_W   = 2,
   parameter int DATA_W    = 16,
   parameter int PANIC_POS = 7
) (
   input  fn_sel_e            sel,
   input  logic [ADC_W-1:0]   adc_q,
   input  logic [TOUCH_W-1:0] touch_s,
   input  logic               panic_s,
   output logic [DATA_W-1:0]  data
);
   always_comb begin
      data = '0;
      unique case (sel)
         SEL_CONV:  data[ADC_W-1:0] = adc_q;
         SEL_SENSE: begin
            data[TOUCH_W-1:0] = touch_s;
            data[PANIC_POS]   = panic_s;
         end
         default:   data = '0;
      endcase
   end
endmodule

// File: rtl/sir_top.sv
module sir_top
   import sir_pkg::*;
#(
   parameter int ADC_W       = 12,
   parameter int TOUCH_W     = 2,
   parameter int DATA_W      = 16,
   parameter int PANIC_POS   = 7,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [1:0]         fn_sel,
   input  logic               rd_stb,
   input  logic               chan_wr,
   input  logic [ADC_W-1:0]   adc_data,
   input  logic               adc_done,
   input  logic [TOUCH_W-1:0] touch_in,
   input  logic               panic_in,
   input  logic               sense_int_en,
   input  logic               host_ien_a,
   input  logic               host_ien_b,
   output logic [DATA_W-1:0]  rd_data,
   output logic               irq_a,
   output logic               irq_b
);
   localparam int SENSE_W = TOUCH_W + 1;

   generate
      if (ADC_W > DATA_W) begin : g_chk_adc
         $error("sir_top: ADC_W exceeds DATA_W");
      end
      if (PANIC_POS < TOUCH_W || PANIC_POS >= DATA_W) begin : g_chk_pos
         $error("sir_top: PANIC_POS overlaps touch field or exceeds word");
      end
   endgenerate

   fn_sel_e sel_e;
   assign sel_e = fn_sel_e'(fn_sel);

   // converter result holding register
   logic [ADC_W-1:0] adc_q;
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)        adc_q <= '0;
      else if (adc_done) adc_q <= adc_data;

   // sensor synchronizer
   logic [SENSE_W-1:0] sense_s;
   sir_sync #(.W(SENSE_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({panic_in, touch_in}),
      .q    (sense_s)
   );

   logic sense_any, sense_prev, sense_rise;
   assign sense_any = |sense_s;
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) sense_prev <= 1'b0;
      else        sense_prev <= sense_any;
   assign sense_rise = sense_any & ~sense_prev;

   // request flags
   logic conv_req, sense_req;
   logic conv_clr, sense_clr;
   assign conv_clr  = chan_wr | (rd_stb && sel_e == SEL_CONV);
   assign sense_clr = rd_stb && sel_e == SEL_SENSE;

   sir_req_flag u_conv_flag (
      .clk(clk), .rst_n(rst_n), .set(adc_done), .clr(conv_clr), .q(conv_req)
   );
   sir_req_flag u_sense_flag (
      .clk(clk), .rst_n(rst_n), .set(sense_rise), .clr(sense_clr), .q(sense_req)
   );

   assign irq_a = conv_req & host_ien_a;
   assign irq_b = sense_req & sense_int_en & host_ien_b;

   sir_rdmux #(
      .ADC_W(ADC_W), .TOUCH_W(TOUCH_W), .DATA_W(DATA_W), .PANIC_POS(PANIC_POS)
   ) u_mux (
      .sel    (sel_e),
      .adc_q  (adc_q),
      .touch_s(sense_s[TOUCH_W-1:0]),
      .panic_s(sense_s[SENSE_W-1]),
      .data   (rd_data)
   );
endmodule

// File: rtl/sir_checker.sv
module sir_checker #(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        fn_sel,
   input logic              rd_stb,
   input logic              chan_wr,
   input logic              adc_done,
   input logic [DATA_W-1:0] rd_data,
   input logic              sense_int_en,
   input logic              host_ien_a,
   input logic              host_ien_b,
   input logic              irq_a,
   input logic              irq_b,
   input logic              conv_req,
   input logic              sense_req,
   input logic              sense_rise
);
   assert_idle_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (fn_sel == 2'b00 || fn_sel == 2'b01) |-> rd_data == '0);
   assert_conv_hi_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fn_sel == 2'b10 |-> rd_data[DATA_W-1:12] == '0);
   assert_done_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
      adc_done |=> conv_req);
   assert_irqa_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !host_ien_a |-> !irq_a);
   assert_wr_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_wr && !adc_done) |=> !conv_req);
   assert_rd_clears_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && fn_sel == 2'b10 && !adc_done) |=> !conv_req);
   assert_rise_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
      sense_rise |=> sense_req);
   assert_irqb_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_b |-> (sense_int_en && host_ien_b));
   assert_rd_clears_b_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && fn_sel == 2'b11 && !sense_rise) |=> !sense_req);
   assert_keep_b_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (sense_req && !(rd_stb && fn_sel == 2'b11)) |=> sense_req);
endmodule

bind sir_top sir_checker #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .fn_sel(fn_sel), .rd_stb(rd_stb), .chan_wr(chan_wr),
   .adc_done(adc_done), .rd_data(rd_data), .sense_int_en(sense_int_en),
   .host_ien_a(host_ien_a), .host_ien_b(host_ien_b), .irq_a(irq_a), .irq_b(irq_b),
   .conv_req(conv_req), .sense_req(sense_req), .sense_rise(sense_rise)
);

// File: tb/tb_sir_top.sv
module tb_sir_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  fn_sel = 2'b00;
   logic        rd_stb = 1'b0, chan_wr = 1'b0, adc_done = 1'b0;
   logic [11:0] adc_data = '0;
   logic [1:0]  touch_in = '0;
   logic        panic_in = 1'b0;
   logic        sense_int_en = 1'b0, host_ien_a = 1'b0, host_ien_b = 1'b0;
   logic [15:0] rd_data;
   logic        irq_a, irq_b;
   int          total = 0, bad = 0;
   bit          done = 1'b0;

   always #5 clk = ~clk;

   sir_top dut (
      .clk(clk), .rst_n(rst_n), .fn_sel(fn_sel), .rd_stb(rd_stb), .chan_wr(chan_wr),
      .adc_data(adc_data), .adc_done(adc_done), .touch_in(touch_in), .panic_in(panic_in),
      .sense_int_en(sense_int_en), .host_ien_a(host_ien_a), .host_ien_b(host_ien_b),
      .rd_data(rd_data), .irq_a(irq_a), .irq_b(irq_b)
   );

   // {sel, adc, touch, panic, expected word}
   localparam logic [32:0] VEC [8] = '{
      {2'b10, 12'hABC, 2'b00, 1'b0, 16'h0ABC},
      {2'b10, 12'hFFF, 2'b00, 1'b0, 16'h0FFF},
      {2'b11, 12'h123, 2'b11, 1'b1, 16'h0083},
      {2'b11, 12'h456, 2'b01, 1'b0, 16'h0001},
      {2'b11, 12'h789, 2'b10, 1'b1, 16'h0082},
      {2'b00, 12'h555, 2'b11, 1'b1, 16'h0000},
      {2'b01, 12'hAAA, 2'b11, 1'b1, 16'h0000},
      {2'b10, 12'h000, 2'b00, 1'b0, 16'h0000}
   };

   task automatic step(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic pulse_done(input logic [11:0] v);
      @(negedge clk); adc_data = v; adc_done = 1'b1;
      @(negedge clk); adc_done = 1'b0; #1;
   endtask

   task automatic host_read(input logic [1:0] s);
      @(negedge clk); fn_sel = s; rd_stb = 1'b1;
      @(negedge clk); rd_stb = 1'b0; #1;
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      step(3);
      // R1 reset state
      for (int s = 0; s < 4; s++) begin
         fn_sel = s[1:0]; #1;
         chk("R1 rd_data after reset", rd_data, 16'h0000);
      end
      chk("R1 irq_a after reset", {15'b0, irq_a}, 16'h0);
      chk("R1 irq_b after reset", {15'b0, irq_b}, 16'h0);
      rst_n = 1'b1;
      step(2);

      // table of read-word vectors: R2 R3 R4
      for (int i = 0; i < 8; i++) begin
         touch_in = VEC[i][18:17];
         panic_in = VEC[i][16];
         pulse_done(VEC[i][30:19]);
         fn_sel = VEC[i][32:31];
         step(3);
         chk($sformatf("R2/R3/R4 vector %0d", i), rd_data, VEC[i][15:0]);
      end

      // clean slate
      touch_in = '0; panic_in = 1'b0;
      step(4);
      host_read(2'b10);
      host_read(2'b11);

      // R5 conversion flag and enable gating
      host_ien_a = 1'b0;
      pulse_done(12'h321);
      chk("R5 irq_a gated off", {15'b0, irq_a}, 16'h0);
      host_ien_a = 1'b1; #1;
      chk("R5 irq_a after done", {15'b0, irq_a}, 16'h1);
      // R7 other-select reads keep it
      host_read(2'b11);
      chk("R7 sense read keeps irq_a", {15'b0, irq_a}, 16'h1);
      host_read(2'b00);
      chk("R7 sel0 read keeps irq_a", {15'b0, irq_a}, 16'h1);
      host_read(2'b10);
      chk("R7 conv read clears irq_a", {15'b0, irq_a}, 16'h0);
      // R6 channel write clears
      pulse_done(12'h111);
      chk("R6 irq_a set before write", {15'b0, irq_a}, 16'h1);
      @(negedge clk); chan_wr = 1'b1;
      @(negedge clk); chan_wr = 1'b0; #1;
      chk("R6 channel write clears irq_a", {15'b0, irq_a}, 16'h0);
      // R8 collisions
      @(negedge clk); chan_wr = 1'b1; adc_done = 1'b1; adc_data = 12'h222;
      @(negedge clk); chan_wr = 1'b0; adc_done = 1'b0; #1;
      chk("R8 done beats channel write", {15'b0, irq_a}, 16'h1);
      @(negedge clk); fn_sel = 2'b10; rd_stb = 1'b1; adc_done = 1'b1; adc_data = 12'h333;
      @(negedge clk); rd_stb = 1'b0; adc_done = 1'b0; #1;
      chk("R8 done beats conv read", {15'b0, irq_a}, 16'h1);
      chk("R2 latest capture", rd_data, 16'h0333);

      // R9 R10 R11 sensor flag
      sense_int_en = 1'b1; host_ien_b = 1'b1;
      @(negedge clk); panic_in = 1'b1;
      step(4);
      chk("R9 panic rise sets irq_b", {15'b0, irq_b}, 16'h1);
      host_read(2'b11);
      chk("R11 sense read clears irq_b", {15'b0, irq_b}, 16'h0);
      step(5);
      chk("R9 held level no re-request", {15'b0, irq_b}, 16'h0);
      @(negedge clk); panic_in = 1'b0;
      step(4);
      @(negedge clk); touch_in = 2'b10;
      step(4);
      chk("R9 touch rise sets irq_b", {15'b0, irq_b}, 16'h1);
      host_read(2'b10);
      chk("R11 conv read keeps irq_b", {15'b0, irq_b}, 16'h1);
      sense_int_en = 1'b0; #1;
      chk("R10 local enable gates irq_b", {15'b0, irq_b}, 16'h0);
      sense_int_en = 1'b1; host_ien_b = 1'b0; #1;
      chk("R10 host enable gates irq_b", {15'b0, irq_b}, 16'h0);
      host_ien_b = 1'b1; #1;
      chk("R10 flag kept while gated", {15'b0, irq_b}, 16'h1);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule